// File: doc/BRIEF.md
# I2C Bus Recovery Sequencer

This block frees a two-wire bus after a slave device has been left driving the data line low, typically because it was reset or interrupted part way through a byte. A single start pulse makes the block take control of both lines through open-drain pull enables. It issues nine clock pulses with the data line released, enough for the slave to finish any byte and its acknowledge slot. It then forces a stop condition and hands the bus back idle. Before each pulse it checks that the clock line is actually high. A slave that is holding the clock low for clock stretching is waited for, in whole steps of one clock period, up to a fixed bound. When the bound runs out the pulse goes ahead anyway.

Both line inputs pass through two-flop synchronisers before any decision is made. All timing comes from one half-period tick divided down from the system clock frequency given as a parameter. Completion is reported with a one-cycle done pulse, together with the synchronised data-line level captured at that moment, so the caller can tell whether the bus came free. The interface is plain control and status. No data flows through the block, so it has no valid/ready handshake.

Top module: `bus_unjam`

## Requirements
- R1: After reset, and from the cycle after each done pulse, `scl_pull`, `sda_pull`, `busy` and `done` are all 0. A pull output of 1 means the block pulls that line low, and 0 means the line is released; the block has no way to drive a line high.
- R2: The half period D equals CLK_HZ / 1_000_000 * 5 cycles (250 at 50 MHz). When SCL reads high, `scl_pull` first rises 1 cycle after the cycle in which `start` is sampled.
- R3: Exactly nine recovery pulses are issued. Each holds `scl_pull` at 1 for D cycles and then at 0 for D+1 cycles before the next one begins, and `sda_pull` stays 0 until the ninth pulse has finished.
- R4: SCL is sampled through a two-flop synchroniser before each pulse. While it reads low, the block waits in steps of 2D+1 cycles, and the pulse starts at the first step boundary at which the synchronised SCL reads high.
- R5: The stretch wait before one pulse is bounded at 50 steps. After 50 steps with SCL still low, the pulse is issued anyway, at offset 1 + 50*(2D+1), and the sequence continues normally.
- R6: Stop sequence: 2D cycles after the ninth pulse's falling edge, `sda_pull` rises. D cycles later `scl_pull` rises, D cycles after that `scl_pull` falls, and D cycles after that `sda_pull` falls.
- R7: `done` is a single-cycle pulse D cycles after `sda_pull` falls, which is 5508 + f0 cycles after start for first-pulse offset f0 at D = 250. `busy` is 1 from the cycle after start through the done cycle.
- R8: `sda_free` during the done cycle equals the synchronised SDA level captured at completion: 1 if the line is high, 0 if something still holds it low.
- R9: A `start` pulse while `busy` is 1 is ignored: pulse count, stop timing and done timing are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to run a recovery |
| scl_in | input | 1 | Clock line level read back from the pad |
| sda_in | input | 1 | Data line level read back from the pad |
| scl_pull | output | 1 | 1 pulls the clock line low, 0 releases it |
| sda_pull | output | 1 | 1 pulls the data line low, 0 releases it |
| busy | output | 1 | Recovery in progress |
| done | output | 1 | One-cycle completion pulse |
| sda_free | output | 1 | Synchronised data-line level captured at completion |

## Verification
The sequence runs against a modelled slave that keeps SDA low until it has seen a chosen number of falling clock edges, from zero up to twelve. This separates a bus freed during the pulses, one freed only by the stop's own clock edge, and one still stuck at the end. Clock stretching is modelled as SCL held low for a chosen number of cycles from start. Short holds check that the first pulse lands on the correct step boundary after the two-flop delay, and a hold that never ends by itself checks the 50-step bound. Extra start pulses, placed both early and late in a run, show that a second request cannot restart the count or shift the stop timing.

// File: rtl/bus_unjam_pkg.sv
package bus_unjam_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_CHECK,
    ST_WAIT_A,
    ST_WAIT_B,
    ST_LOW,
    ST_HIGH,
    ST_STOP_SDA,
    ST_STOP_SCL,
    ST_STOP_REL,
    ST_STOP_END,
    ST_FIN
  } unjam_state_e;

  // States that last one half-period tick
  function automatic logic is_timed(unjam_state_e s);
    return (s == ST_WAIT_A) || (s == ST_WAIT_B) || (s == ST_LOW) ||
           (s == ST_HIGH) || (s == ST_STOP_SDA) || (s == ST_STOP_SCL) ||
           (s == ST_STOP_REL) || (s == ST_STOP_END);
  endfunction

  function automatic logic pulls_scl(unjam_state_e s);
    return (s == ST_LOW) || (s == ST_STOP_SCL);
  endfunction

  function automatic logic pulls_sda(unjam_state_e s);
    return (s == ST_STOP_SDA) || (s == ST_STOP_SCL) || (s == ST_STOP_REL);
  endfunction

endpackage

// File: rtl/unjam_sync.sv
module unjam_sync #(
  parameter int unsigned W      = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  for (genvar i = 0; i < W; i++) begin : g_line
    logic [STAGES-1:0] sh;
    always_ff @(posedge clk) begin
      if (!rst_n) sh <= '1;
      else        sh <= {sh[STAGES-2:0], d[i]};
    end
    assign q[i] = sh[STAGES-1];
  end

endmodule

// File: rtl/unjam_tick.sv
module unjam_tick #(
  parameter int unsigned DIV = 250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);

  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (en) begin
      if (cnt == LAST)   cnt <= '0;
      else               cnt <= cnt + 1'b1;
    end
  end

  assign tick = en && (cnt == LAST);

  // R2: counter never leaves its range
  p_cnt_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);

  if (DIV > 1) begin : g_gap
    // R2: ticks are separated by at least one cycle
    p_tick_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);
  end

endmodule

// File: rtl/unjam_fsm.sv
module unjam_fsm
  import bus_unjam_pkg::*;
#(
  parameter int unsigned PULSES        = 9,
  parameter int unsigned STRETCH_STEPS = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic tick,
  input  logic scl_s,
  input  logic sda_s,
  output logic tick_en,
  output logic scl_pull,
  output logic sda_pull,
  output logic busy,
  output logic done,
  output logic sda_free
);

  localparam int unsigned PCW = $clog2(PULSES + 1);
  localparam int unsigned WCW = $clog2(STRETCH_STEPS + 1);
  localparam logic [PCW-1:0] LAST_PULSE = PCW'(PULSES - 1);
  localparam logic [PCW-1:0] ALL_PULSES = PCW'(PULSES);
  localparam logic [WCW-1:0] WAIT_MAX   = WCW'(STRETCH_STEPS);

  unjam_state_e state, state_n;
  logic [PCW-1:0] pulse_cnt;
  logic [WCW-1:0] wait_cnt;

  assign tick_en = is_timed(state);

  always_comb begin
    state_n = state;
    unique case (state)
      ST_IDLE:     if (start) state_n = ST_CHECK;
      ST_CHECK:    state_n = (scl_s || (wait_cnt == WAIT_MAX)) ? ST_LOW : ST_WAIT_A;
      ST_WAIT_A:   if (tick) state_n = ST_WAIT_B;
      ST_WAIT_B:   if (tick) state_n = ST_CHECK;
      ST_LOW:      if (tick) state_n = ST_HIGH;
      ST_HIGH:     if (tick) state_n = (pulse_cnt == LAST_PULSE) ? ST_STOP_SDA : ST_CHECK;
      ST_STOP_SDA: if (tick) state_n = ST_STOP_SCL;
      ST_STOP_SCL: if (tick) state_n = ST_STOP_REL;
      ST_STOP_REL: if (tick) state_n = ST_STOP_END;
      ST_STOP_END: if (tick) state_n = ST_FIN;
      ST_FIN:      state_n = ST_IDLE;
      default:     state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      pulse_cnt <= '0;
      wait_cnt  <= '0;
      scl_pull  <= 1'b0;
      sda_pull  <= 1'b0;
      busy      <= 1'b0;
      done      <= 1'b0;
      sda_free  <= 1'b0;
    end else begin
      state    <= state_n;
      scl_pull <= pulls_scl(state_n);
      sda_pull <= pulls_sda(state_n);
      busy     <= (state_n != ST_IDLE);
      done     <= (state_n == ST_FIN);
      if (state == ST_IDLE && start) begin
        pulse_cnt <= '0;
        wait_cnt  <= '0;
      end
      if (state == ST_WAIT_B && tick) wait_cnt <= wait_cnt + 1'b1;
      if (state == ST_HIGH && tick) begin
        pulse_cnt <= pulse_cnt + 1'b1;
        wait_cnt  <= '0;
      end
      if (state == ST_STOP_END && tick) sda_free <= sda_s;
    end
  end

  // R5: the stretch wait never exceeds its bound
  p_wait_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wait_cnt <= WAIT_MAX);

  // R3: SDA stays released while recovery pulses remain
  p_sda_released_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_cnt < ALL_PULSES) |-> !sda_pull);

  // R6: SDA is pulled low only while SCL is released (stop setup)
  p_stop_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull) |-> !scl_pull);

  // R7: done lasts one cycle
  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R1: idle means both lines released
  p_idle_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!scl_pull && !sda_pull));

  // R9: a start during a run never rewinds the pulse count
  p_ignore_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done && start) |=> (pulse_cnt >= $past(pulse_cnt)));

endmodule

// File: rtl/bus_unjam.sv
module bus_unjam #(
  parameter int unsigned CLK_HZ        = 50_000_000,
  parameter int unsigned HALF_US       = 5,
  parameter int unsigned PULSES        = 9,
  parameter int unsigned STRETCH_STEPS = 50,
  parameter int unsigned SYNC_STAGES   = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_pull,
  output logic sda_pull,
  output logic busy,
  output logic done,
  output logic sda_free
);

  localparam int unsigned HALF_DIV = (CLK_HZ / 1_000_000) * HALF_US;

  logic [1:0] lines_q;
  logic       tick;
  logic       tick_en;

  unjam_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({sda_in, scl_in}),
    .q     (lines_q)
  );

  unjam_tick #(.DIV(HALF_DIV)) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (tick_en),
    .tick  (tick)
  );

  unjam_fsm #(.PULSES(PULSES), .STRETCH_STEPS(STRETCH_STEPS)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .tick     (tick),
    .scl_s    (lines_q[0]),
    .sda_s    (lines_q[1]),
    .tick_en  (tick_en),
    .scl_pull (scl_pull),
    .sda_pull (sda_pull),
    .busy     (busy),
    .done     (done),
    .sda_free (sda_free)
  );

endmodule

// File: tb/tb_bus_unjam.sv
module tb_bus_unjam;

  localparam int CLK_HZ = 50_000_000;
  localparam int D      = (CLK_HZ / 1_000_000) * 5;
  localparam int STEP   = 2 * D + 1;
  localparam int RUN_LIMIT = 40000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic scl_pull, sda_pull, busy, done, sda_free;

  int stretch_left = 0;
  bit slave_hold = 1'b0;
  int n_chk = 0;
  int n_fail = 0;

  wire scl_in = !scl_pull && (stretch_left == 0);
  wire sda_in = !sda_pull && !slave_hold;

  always #10 clk = ~clk;

  bus_unjam #(.CLK_HZ(CLK_HZ)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .scl_in(scl_in), .sda_in(sda_in),
    .scl_pull(scl_pull), .sda_pull(sda_pull), .busy(busy), .done(done),
    .sda_free(sda_free)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_first(input int s_len);
    int w;
    if (s_len == 0) return 1;
    w = (s_len + 2 + STEP - 1) / STEP;
    if (w > 50) w = 50;
    return 1 + w * STEP;
  endfunction

  task automatic run_case(input int n_slave, input int s_len, input int dup_at);
    int sf[16];
    int sr[16];
    int nf = 0, nr = 0, ndf = 0, ndr = 0, dfall = 0, drise = 0;
    int done_off = 0, ndone = 0, busy_gap = 0, mp = 0;
    int f0, bad_k, act_v, exp_v, base;
    bit free_seen = 1'b0, fin = 1'b0, pscl = 1'b0, psda = 1'b0, pulses_ok;
    for (int i = 0; i < 16; i++) begin sf[i] = 0; sr[i] = 0; end
    slave_hold = (n_slave > 0);
    stretch_left = s_len;
    repeat (3) @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int t = 1; t <= RUN_LIMIT && !fin; t++) begin
      @(negedge clk);
      start = (t == dup_at);
      if (scl_pull) stretch_left = 0;
      else if (stretch_left > 0) stretch_left--;
      if (scl_pull && !pscl) begin
        if (nf < 16) sf[nf] = t;
        nf++; mp++;
        if (mp >= n_slave) slave_hold = 1'b0;
      end
      if (!scl_pull && pscl) begin
        if (nr < 16) sr[nr] = t;
        nr++;
      end
      if (sda_pull && !psda) begin dfall = t; ndf++; end
      if (!sda_pull && psda) begin drise = t; ndr++; end
      pscl = scl_pull;
      psda = sda_pull;
      if (!busy) busy_gap++;
      if (done) begin ndone++; done_off = t; free_seen = sda_free; fin = 1'b1; end
    end
    start = 1'b0;
    chk(fin, "R7", "watchdog: run finished", int'(fin), 1);

    f0 = exp_first(s_len);
    if (s_len > 50 * STEP) chk(sf[0] == f0, "R5", "first pulse after stretch bound", sf[0], f0);
    else if (s_len > 0)    chk(sf[0] == f0, "R4", "first pulse after stretch", sf[0], f0);
    else                   chk(sf[0] == f0, "R2", "first pulse offset", sf[0], f0);

    chk(nf == 10 && nr == 10, "R3", "SCL low intervals (9 pulses + stop)", nf, 10);
    pulses_ok = 1'b1; bad_k = -1;
    for (int k = 0; k < 9; k++) begin
      if (sf[k] != f0 + k * STEP || sr[k] != f0 + k * STEP + D) begin
        if (pulses_ok) bad_k = k;
        pulses_ok = 1'b0;
      end
    end
    act_v = (bad_k < 0) ? 0 : sf[bad_k];
    exp_v = (bad_k < 0) ? 0 : f0 + bad_k * STEP;
    chk(pulses_ok, "R3", "pulse timing", act_v, exp_v);

    base = f0 + 8 * STEP;
    chk(ndf == 1 && ndr == 1, "R6", "SDA pulled exactly once", ndf, 1);
    chk(dfall == base + 2 * D, "R6", "stop SDA fall", dfall, base + 2 * D);
    chk(sf[9] == base + 3 * D, "R6", "stop SCL fall", sf[9], base + 3 * D);
    chk(sr[9] == base + 4 * D, "R6", "stop SCL release", sr[9], base + 4 * D);
    chk(drise == base + 5 * D, "R6", "stop SDA release", drise, base + 5 * D);
    chk(done_off == base + 6 * D && ndone == 1, "R7", "done offset", done_off, base + 6 * D);
    chk(busy_gap == 0, "R7", "busy held during run", busy_gap, 0);
    chk(free_seen == (n_slave <= 10), "R8", "sda_free", int'(free_seen), int'(n_slave <= 10));
    if (dup_at > 0)
      chk(nf == 10 && done_off == base + 6 * D, "R9", "start while busy ignored", done_off, base + 6 * D);

    @(negedge clk);
    chk(!busy && !done && !scl_pull && !sda_pull, "R1", "released after completion",
        {busy, done, scl_pull, sda_pull}, 0);
    slave_hold = 1'b0;
  endtask

  initial begin : watchdog
    repeat (195000) @(posedge clk);
    $display("FAIL R7 watchdog expired: actual 0 expected 1");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk + 1, n_fail + 1);
    $finish;
  end

  initial begin : main
    int seed_v, n_r, s_r, d_r;
    seed_v = $urandom(32'd20240);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !scl_pull && !sda_pull, "R1", "reset state",
        {busy, done, scl_pull, sda_pull}, 0);

    run_case(0, 0, 0);        // R2 R3: clean bus
    run_case(12, 0, 0);       // R8: still stuck at end
    run_case(10, 0, 0);       // R8: freed by stop clock edge
    run_case(11, 0, 0);       // R8: first count that stays stuck
    run_case(3, 30000, 0);    // R5: stretch never ends by itself
    run_case(2, 700, 0);      // R4: one step boundary
    run_case(5, 0, 1);        // R9: start right after acceptance
    run_case(4, 0, 4800);     // R9: start during stop sequence

    for (int i = 0; i < 5; i++) begin
      n_r = $urandom_range(12, 0);
      s_r = ($urandom_range(1, 0) == 1) ? $urandom_range(4000, 1) : 0;
      d_r = ($urandom_range(1, 0) == 1) ? $urandom_range(5000, 1) : 0;
      run_case(n_r, s_r, d_r);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule